// File: doc/BRIEF.md
# Stochastic Bitstream Arithmetic Datapath

This block does multiplication and scaled addition on probability-coded serial bitstreams in place of binary arithmetic. A start strobe captures two W-bit operands and an operation code. Each operand then drives its own pseudo-random stream source. A source is a maximal-length Galois LFSR with its own nonzero seed, followed by a magnitude comparator. On each clock the source emits a 1 when its LFSR value is below the captured operand, so the fraction of 1s in the stream is close to operand / 2^W.

A single gate combines the two operand streams. AND gives an unsigned product. XNOR gives a signed product, where operand v stands for (2v − 2^W) / 2^W. A 2:1 selector gives the halved sum; it is steered by a third stream with probability one half, and that stream comes from its own LFSR. A ones counter watches the gate output for exactly 2^W clocks. It then posts the result for one cycle and holds the value until the next completion. In signed mode the count c is posted as 2c − 2^W in two's complement.

Top module: `sc_stream_datapath`

## Requirements
- R1: After reset, done is 0 and result is 0.
- R2: A start sampled at clock edge E0 produces done high for exactly the one cycle after edge E0+2^W, unless another start comes first.
- R3: A start sampled while a run is in progress discards that run and begins a new one. This includes a start on the last counting edge, which means no done at that edge. The new run completes 2^W edges later.
- R4: result changes only at the edge that raises done, and holds its value between completions.
- R5: op_sel 2'b00 (and the spare code 2'b11) gives an unsigned product. result is about opnd_a·opnd_b / 2^W, within 2^W/8. A zero operand gives exactly 0.
- R6: op_sel 2'b01 gives a signed product, reported as 2c − 2^W with c the ones count. It lies within ±2^W. When both operands are 0 (both −1), result is exactly +2^W.
- R7: op_sel 2'b10 gives a scaled sum, about (opnd_a + opnd_b)/2 within 2^W/8. Two zero operands give exactly 0.
- R8: The two operand streams are statistically independent. Squaring a value through equal operands gives about a²/2^W, not a.
- R9: Changes to opnd_a, opnd_b and op_sel after the start edge have no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; captures operands and op_sel |
| op_sel | input | 2 | 00 unsigned product, 01 signed product, 10 scaled sum, 11 as 00 |
| opnd_a | input | W | First binary operand |
| opnd_b | input | W | Second binary operand |
| result | output | W+2 | Decoded ones count (two's complement in signed mode) |
| done | output | 1 | One-cycle completion pulse |

## Verification
A new start and the completion of the current run can fall in the same clock edge. The bench provokes this by raising start exactly on the last counting edge of a run. A cycle-accurate reference of the run timing then has to show that no done appears at that edge. It also has to show that done appears 2^W edges later, carrying the result for the new operands and not the discarded ones. An extra mid-run restart and a mid-run change of the operands check the same capture path.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [1:0] {
        OP_UMUL = 2'b00,
        OP_BMUL = 2'b01,
        OP_SADD = 2'b10,
        OP_SPARE = 2'b11
    } sc_op_e;

    typedef struct packed {
        logic a;
        logic b;
        logic s;
    } sc_bits_t;

    // Galois feedback masks for maximal-length sequences
    function automatic logic [15:0] lfsr_mask(input int w);
        case (w)
            4:  return 16'h000C;
            5:  return 16'h0014;
            6:  return 16'h0030;
            7:  return 16'h0060;
            8:  return 16'h00B8;
            9:  return 16'h0110;
            10: return 16'h0240;
            11: return 16'h0500;
            12: return 16'h0E08;
            13: return 16'h1C80;
            14: return 16'h3802;
            15: return 16'h6000;
            default: return 16'hD008;
        endcase
    endfunction

endpackage

// File: rtl/sc_lfsr_source.sv
module sc_lfsr_source #(
    parameter int W = 8,
    parameter int SEED = 1,
    parameter bit REVERSE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] thresh,
    output logic         bit_o
);
    import sc_pkg::*;

    localparam logic [W-1:0] MASK = W'(lfsr_mask(W));
    localparam logic [W-1:0] SEED_RAW = W'(SEED);
    localparam logic [W-1:0] SEED_V = (SEED_RAW == '0) ? W'(1) : SEED_RAW;

    logic [W-1:0] state;
    logic [W-1:0] cmp_val;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            state <= SEED_V;
        end else if (step) begin
            state <= state[0] ? ((state >> 1) ^ MASK) : (state >> 1);
        end
    end

    generate
        if (REVERSE) begin : g_rev
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign cmp_val[i] = state[W-1-i];
            end
        end else begin : g_fwd
            assign cmp_val = state;
        end
    endgenerate

    assign bit_o = (cmp_val < thresh);

endmodule

// File: rtl/sc_gate_op.sv
module sc_gate_op (
    input  sc_pkg::sc_op_e   op,
    input  sc_pkg::sc_bits_t bits,
    output logic             y
);
    import sc_pkg::*;

    always_comb begin
        case (op)
            OP_BMUL: y = ~(bits.a ^ bits.b);
            OP_SADD: y = bits.s ? bits.b : bits.a;
            default: y = bits.a & bits.b;
        endcase
    end

endmodule

// File: rtl/sc_count_decode.sv
module sc_count_decode #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           bit_i,
    input  sc_pkg::sc_op_e op,
    output logic           busy,
    output logic           done,
    output logic [W+1:0]   result
);
    import sc_pkg::*;

    localparam int LEN = 1 << W;
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] tick;
    logic [W:0]   ones;
    logic [W:0]   ones_nxt;
    logic [W+1:0] decoded;

    assign ones_nxt = ones + (W+1)'(bit_i);

    always_comb begin
        if (op == OP_BMUL) begin
            decoded = {ones_nxt, 1'b0} - (W+2)'(LEN);
        end else begin
            decoded = {1'b0, ones_nxt};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            tick   <= '0;
            ones   <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                tick <= '0;
                ones <= '0;
            end else if (busy) begin
                ones <= ones_nxt;
                tick <= tick + 1'b1;
                if (tick == LAST) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    result <= decoded;
                end
            end
        end
    end

endmodule

// File: rtl/sc_stream_datapath.sv
module sc_stream_datapath #(
    parameter int W = 8,
    parameter int SEED_A = 'h5D,
    parameter int SEED_B = 'hA7,
    parameter int SEED_S = 'h3C
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W+1:0] result,
    output logic         done
);
    import sc_pkg::*;

    localparam logic [W-1:0] HALF = W'(1 << (W - 1));

    sc_op_e       op_q;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         busy;
    sc_bits_t     bits;
    logic         gate_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= OP_UMUL;
            a_q  <= '0;
            b_q  <= '0;
        end else if (start) begin
            op_q <= sc_op_e'(op_sel);
            a_q  <= opnd_a;
            b_q  <= opnd_b;
        end
    end

    sc_lfsr_source #(.W(W), .SEED(SEED_A), .REVERSE(1'b0)) i_src_a (
        .clk(clk), .rst(rst), .load(start), .step(busy),
        .thresh(a_q), .bit_o(bits.a)
    );

    sc_lfsr_source #(.W(W), .SEED(SEED_B), .REVERSE(1'b1)) i_src_b (
        .clk(clk), .rst(rst), .load(start), .step(busy),
        .thresh(b_q), .bit_o(bits.b)
    );

    sc_lfsr_source #(.W(W), .SEED(SEED_S), .REVERSE(1'b0)) i_src_s (
        .clk(clk), .rst(rst), .load(start), .step(busy),
        .thresh(HALF), .bit_o(bits.s)
    );

    sc_gate_op i_gate (
        .op(op_q), .bits(bits), .y(gate_y)
    );

    sc_count_decode #(.W(W)) i_count (
        .clk(clk), .rst(rst), .start(start), .bit_i(gate_y), .op(op_q),
        .busy(busy), .done(done), .result(result)
    );

endmodule

// File: rtl/sc_stream_checker.sv
module sc_stream_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         done,
    input logic [W+1:0] result
);
    localparam int LEN = 1 << W;

    logic       armed;
    logic [W:0] since;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            since <= '0;
        end else if (start) begin
            armed <= 1'b1;
            since <= '0;
        end else if (done) begin
            armed <= 1'b0;
        end else if (armed && since != (W+1)'(LEN)) begin
            since <= since + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!done && result == '0));

    assert_done_timing_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (armed && since == (W+1)'(LEN)));

    assert_done_not_missed_R2: assert property (@(posedge clk) disable iff (rst)
        (armed && since == (W+1)'(LEN)) |-> done);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_restart_no_done_R3: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

    assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

    assert_result_range_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($signed(result) <= $signed((W+2)'(LEN)) &&
                  $signed(result) >= -$signed((W+2)'(LEN))));

endmodule

bind sc_stream_datapath sc_stream_checker #(.W(W)) i_sc_stream_checker (
    .clk(clk), .rst(rst), .start(start), .done(done), .result(result)
);

// File: tb/test_sc_stream_datapath.sv
module test_sc_stream_datapath;
    localparam int W = 8;
    localparam int LEN = 1 << W;
    localparam int TOL = LEN / 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W+1:0] result;
    logic         done;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // reference timing model
    bit mrun = 1'b0;
    bit mdone = 1'b0;
    int mcnt = 0;

    always #10 clk = ~clk;

    sc_stream_datapath #(.W(W)) i_sc_stream_datapath (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .done(done)
    );

    always @(posedge clk) begin
        if (rst) begin
            mrun = 1'b0; mdone = 1'b0; mcnt = 0;
        end else if (start) begin
            mrun = 1'b1; mdone = 1'b0; mcnt = 0;
        end else if (mrun) begin
            mcnt++;
            mdone = (mcnt == LEN);
            if (mdone) mrun = 1'b0;
        end else begin
            mdone = 1'b0;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst && !finished) begin
            compared++;
            if (done !== mdone) begin
                mismatched++;
                $display("FAIL R2/R3 done timing at cycle %0d: actual %0b expected %0b",
                         cycles, done, mdone);
            end
        end
        if (cycles > 150000 && !finished) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic check(input string tag, input int act, input int exp, input int tol);
        compared++;
        if (act > exp + tol || act < exp - tol) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, exp, tol);
        end
    endtask

    task automatic kick(input logic [1:0] op, input int a, input int b);
        @(negedge clk);
        op_sel = op; opnd_a = W'(a); opnd_b = W'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic await(output int res);
        res = 'x;
        for (int k = 0; k < LEN + 8; k++) begin
            @(negedge clk);
            if (done) begin
                res = int'($signed(result));
                return;
            end
        end
        mismatched++;
        $display("FAIL R2: actual no done expected done within %0d cycles", LEN);
    endtask

    task automatic run(input string tag, input logic [1:0] op, input int a, input int b,
                       input int exp, input int tol);
        int r;
        kick(op, a, b);
        await(r);
        check(tag, r, exp, tol);
    endtask

    initial begin
        int r;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done after reset", int'(done), 0, 0);
        check("R1 result after reset", int'(result), 0, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R5 unsigned product
        run("R5 umul 200x100", 2'b00, 200, 100, 200 * 100 / LEN, TOL);
        run("R5 umul zero a", 2'b00, 0, 255, 0, 0);
        run("R5 umul 255x255", 2'b00, 255, 255, 255 * 255 / LEN, TOL);
        run("R5 spare code 11 as umul zero", 2'b11, 90, 0, 0, 0);

        // R6 signed product
        run("R6 bmul -1*-1", 2'b01, 0, 0, LEN, 0);
        run("R6 bmul 0.5*0.5", 2'b01, 192, 192, LEN / 4, 2 * TOL);
        run("R6 bmul -0.5*0.5", 2'b01, 64, 192, -LEN / 4, 2 * TOL);

        // R7 scaled sum
        run("R7 sadd 200,40", 2'b10, 200, 40, 120, TOL);
        run("R7 sadd zero", 2'b10, 0, 0, 0, 0);

        // R8 independence: equal operands must square, not copy
        run("R8 umul 128x128", 2'b00, 128, 128, 64, TOL);

        // R4 result holds between completions
        repeat (20) @(negedge clk);
        check("R4 result held", int'($signed(result)), 64, TOL);

        // R9 inputs changed mid-run are ignored
        kick(2'b00, 0, 255);
        op_sel = 2'b01; opnd_a = 8'd255; opnd_b = 8'd0;
        await(r);
        check("R9 mid-run operand change", r, 0, 0);

        // R3 restart mid-run
        kick(2'b00, 255, 255);
        repeat (100) @(negedge clk);
        kick(2'b00, 0, 77);
        await(r);
        check("R3 mid-run restart result", r, 0, 0);

        // R3 start on the final counting edge
        kick(2'b00, 255, 255);
        repeat (LEN - 1) @(negedge clk);
        op_sel = 2'b10; opnd_a = '0; opnd_b = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R3 no done on colliding edge", int'(done), 0, 0);
        await(r);
        check("R3 collided restart result", r, 0, 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule